// File: doc/BRIEF.md
# PHY Management Register Bank

This block holds the management registers of an Ethernet-style transceiver: thirty-two 16-bit locations reached through a plain register port, which a serial management front end drives one access at a time. Every bit has its own access rule. Some bits are read-write. Some are read-only views of live status. Some are permanent constants. Some clear themselves. Some latch an event until the register is read: one kind latches low, one latches high, and one clears on read.

Link-side logic feeds status into the bank as level or pulse inputs. The bank drives the transceiver's control outputs: loopback, power down, isolate, collision test, negotiation enable and restart, and a forced speed and duplex used when negotiation is off.

Setting the top bit of the control register starts a timed soft reset. The reset runs for a parameter number of clock cycles. While it runs, the bank reports busy, and at the end it returns every register to its default. Fields whose defaults come from strap pins reload the values captured once after power-on reset, not the current pin levels.

Top module: `mgmt_regbank`

## Requirements
- R1: Writing 1 to bit 15 of address 0 makes `reset_busy` and bit 15 of address 0 read 1 for exactly RST_CYCLES cycles. When the reset completes, every register returns to its default and the latched bits return to 0. Writing bit 15 again while busy has no effect.
- R2: Strap-derived defaults are captured once, on the first clock after power-on reset: address 0 bits 13 (speed), 12 (negotiation enable) and 8 (duplex), and address 4 bits 8:5 (ability bits, strap_adv[3] in bit 8). A soft reset reloads the captured values even if the pins have changed since.
- R3: Address 1 bit 2 (link) latches low. It clears while `link_good` is 0. It becomes 1 only on the cycle after a read of address 1 taken while `link_good` is 1.
- R4: Address 1 bit 1 (jabber) latches high. It is set the cycle after a `jabber_evt` pulse and stays set until a read of address 1 or a reset.
- R5: Address 0 bit 9 (restart negotiation, driven on `ctl_aneg_restart`) is set by a write only when the same write sets bit 12. Writing 0 to bit 9 does not cancel it. It clears on `aneg_started`, or when a write clears bit 12.
- R6: While bit 12 of address 0 is 1, `ctl_forced_100` and `ctl_forced_full` are 0. While bit 12 is 0, they follow bit 13 and bit 8.
- R7: Address 6 bit 1 (page received) sets on `page_rx_evt` and clears on the cycle after a read of address 6.
- R8: Address 1 reads 0x7849 plus the live `aneg_done` in bit 5 and the latched bits 2 and 1. Address 6 bit 2 reads 1. Address 4 bits 4:0 read 00001. None of these constant bits can be changed by a write.
- R9: Addresses 2 and 3 read the ID_HI and ID_LO parameters and ignore writes. Addresses 5 and 7 to 31 read 0 and ignore writes.
- R10: Address 0 bits 6:0 read 0 and ignore writes. Bits 14, 11, 10 and 7 are read-write and drive `ctl_loopback`, `ctl_power_down`, `ctl_isolate` and `ctl_col_test`.
- R11: When a latch event and a read of its register fall in the same cycle, the event wins and the latch keeps its event state.
- R12: A write that lands while a soft reset is in progress is accepted, then replaced by the defaults when the reset completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_rd | input | 1 | Read strobe (triggers read side effects) |
| mgmt_addr | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data for mgmt_addr (combinational) |
| strap_speed100 | input | 1 | Strap: default speed 100 Mb/s |
| strap_aneg_en | input | 1 | Strap: default negotiation enable |
| strap_full_duplex | input | 1 | Strap: default full duplex |
| strap_adv | input | 4 | Strap: default advertised abilities |
| link_good | input | 1 | Link is currently valid (level) |
| jabber_evt | input | 1 | Jabber detected (pulse) |
| page_rx_evt | input | 1 | Link code word received (pulse) |
| aneg_done | input | 1 | Negotiation complete (level) |
| aneg_started | input | 1 | Negotiation engine has restarted (pulse) |
| reset_busy | output | 1 | Soft reset in progress |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_power_down | output | 1 | Power down |
| ctl_isolate | output | 1 | Isolate |
| ctl_col_test | output | 1 | Collision test |
| ctl_aneg_en | output | 1 | Negotiation enable |
| ctl_aneg_restart | output | 1 | Restart negotiation request |
| ctl_forced_100 | output | 1 | Forced 100 Mb/s (negotiation off) |
| ctl_forced_full | output | 1 | Forced full duplex (negotiation off) |

## Verification
The bench targets the release timing of each latch. A latch that released on the read cycle itself, instead of the cycle after, would return the released value on the strobe cycle. A read colliding with an event would lose a link drop or a jabber pulse, and the bench expects the latch to keep its event state. The soft reset is timed by counting busy cycles, so an off-by-one counter is caught. After the pins change, the reset must reload the captured strap values; a design that resampled the pins, or cleared the strap fields to zero, would read back the wrong control word. The restart bit is driven through its set, hold and ignore paths, and writes to constant, identifier and unused locations are read back to confirm they change nothing.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 16;

  localparam logic [AW-1:0] A_CTRL  = 5'd0;
  localparam logic [AW-1:0] A_STAT  = 5'd1;
  localparam logic [AW-1:0] A_ID_HI = 5'd2;
  localparam logic [AW-1:0] A_ID_LO = 5'd3;
  localparam logic [AW-1:0] A_ADV   = 5'd4;
  localparam logic [AW-1:0] A_EXP   = 5'd6;

  // fixed bits of the status and expansion words
  localparam logic [DW-1:0] STAT_FIXED = 16'h7849;
  localparam logic [DW-1:0] EXP_FIXED  = 16'h0004;

  typedef struct packed {
    logic       spd100;
    logic       an_en;
    logic       full;
    logic [3:0] abil;
  } strap_t;

  typedef enum logic {STK_HIGH, STK_LOW} stk_kind_e;
endpackage

// File: rtl/mgmt_reset_seq.sv
module mgmt_reset_seq
  import mgmt_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 200
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_req,
  input  strap_t pins,
  output logic   busy,
  output logic   done,
  output strap_t dflt
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          held_q, held_d;
  strap_t        cap_q;
  logic          cap_en;

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;
  assign dflt = held_q ? cap_q : pins;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    held_d = held_q;
    cap_en = 1'b0;
    if (done) begin
      busy_d = 1'b0;
      held_d = 1'b1;
      cap_en = !held_q;
    end else if (start_req && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CW'(RST_CYCLES - 1);
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  // power-on reset behaves as a zero-length soft reset that also samples the straps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      held_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      held_q <= held_d;
      if (cap_en) cap_q <= pins;
    end
  end
endmodule

// File: rtl/mgmt_sticky_bit.sv
module mgmt_sticky_bit
  import mgmt_pkg::*;
#(
  parameter stk_kind_e KIND = STK_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  input  logic rd_hit,
  output logic q
);
  logic q_r, q_d;

  generate
    if (KIND == STK_HIGH) begin : g_high
      always_comb q_d = clr ? 1'b0 : (evt | (q_r & ~rd_hit));
    end else begin : g_low
      always_comb q_d = clr ? 1'b0 : (~evt & (q_r | rd_hit));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/mgmt_rw_regs.sv
module mgmt_rw_regs
  import mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_adv,
  input  logic [DW-1:0] wdata,
  input  logic          an_started,
  input  logic          load_dflt,
  input  strap_t        dflt,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] adv_q
);
  localparam logic [DW-1:0] CTRL_MASK = 16'h7D80;
  localparam logic [DW-1:0] ADV_MASK  = 16'hADE0;
  localparam logic [DW-1:0] ADV_SEL   = 16'h0001;
  localparam int unsigned   B_SPD = 13;
  localparam int unsigned   B_AN  = 12;
  localparam int unsigned   B_RS  = 9;
  localparam int unsigned   B_DUP = 8;
  localparam int unsigned   ABIL_LSB = 5;

  logic [DW-1:0] ctrl_r, ctrl_d, adv_r, adv_d;
  logic          rs_q, rs_d;
  logic          ctrl_en, adv_en;

  assign ctrl_en = load_dflt | wr_ctrl;
  assign adv_en  = load_dflt | wr_adv;

  always_comb begin
    ctrl_d = ctrl_r;
    adv_d  = adv_r;
    rs_d   = rs_q & ~an_started;
    if (load_dflt) begin
      ctrl_d        = '0;
      ctrl_d[B_SPD] = dflt.spd100;
      ctrl_d[B_AN]  = dflt.an_en;
      ctrl_d[B_DUP] = dflt.full;
      adv_d         = ADV_SEL | (DW'(dflt.abil) << ABIL_LSB);
      rs_d          = 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_d = wdata & CTRL_MASK;
        rs_d   = wdata[B_AN] & (wdata[B_RS] | (rs_q & ~an_started));
      end
      if (wr_adv) adv_d = (wdata & ADV_MASK) | ADV_SEL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      adv_r  <= '0;
      rs_q   <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_r <= ctrl_d;
      if (adv_en)  adv_r  <= adv_d;
      rs_q <= rs_d;
    end
  end

  assign ctrl_q = ctrl_r | (DW'(rs_q) << B_RS);
  assign adv_q  = adv_r;
endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
  import mgmt_pkg::*;
#(
  parameter int unsigned     RST_CYCLES = 200,
  parameter logic [DW-1:0]   ID_HI      = 16'h2000,
  parameter logic [DW-1:0]   ID_LO      = 16'h5C90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mgmt_wr,
  input  logic          mgmt_rd,
  input  logic [AW-1:0] mgmt_addr,
  input  logic [DW-1:0] mgmt_wdata,
  output logic [DW-1:0] mgmt_rdata,
  input  logic          strap_speed100,
  input  logic          strap_aneg_en,
  input  logic          strap_full_duplex,
  input  logic [3:0]    strap_adv,
  input  logic          link_good,
  input  logic          jabber_evt,
  input  logic          page_rx_evt,
  input  logic          aneg_done,
  input  logic          aneg_started,
  output logic          reset_busy,
  output logic          ctl_loopback,
  output logic          ctl_power_down,
  output logic          ctl_isolate,
  output logic          ctl_col_test,
  output logic          ctl_aneg_en,
  output logic          ctl_aneg_restart,
  output logic          ctl_forced_100,
  output logic          ctl_forced_full
);
  strap_t        pins_s, dflt_s;
  logic          wr_ctrl, wr_adv, start_req, rd_stat, rd_exp;
  logic          busy, done;
  logic          lnk_q, jab_q, pg_q;
  logic [DW-1:0] ctrl_q, adv_q;

  assign pins_s    = {strap_speed100, strap_aneg_en, strap_full_duplex, strap_adv};
  assign wr_ctrl   = mgmt_wr && (mgmt_addr == A_CTRL);
  assign wr_adv    = mgmt_wr && (mgmt_addr == A_ADV);
  assign start_req = wr_ctrl && mgmt_wdata[DW-1];
  assign rd_stat   = mgmt_rd && (mgmt_addr == A_STAT);
  assign rd_exp    = mgmt_rd && (mgmt_addr == A_EXP);

  mgmt_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .pins(pins_s),
    .busy(busy), .done(done), .dflt(dflt_s)
  );

  mgmt_rw_regs u_rw (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_adv(wr_adv),
    .wdata(mgmt_wdata), .an_started(aneg_started), .load_dflt(done),
    .dflt(dflt_s), .ctrl_q(ctrl_q), .adv_q(adv_q)
  );

  mgmt_sticky_bit #(.KIND(STK_LOW)) u_link (
    .clk(clk), .rst_n(rst_n), .clr(done), .evt(~link_good),
    .rd_hit(rd_stat), .q(lnk_q)
  );

  mgmt_sticky_bit #(.KIND(STK_HIGH)) u_jab (
    .clk(clk), .rst_n(rst_n), .clr(done), .evt(jabber_evt),
    .rd_hit(rd_stat), .q(jab_q)
  );

  mgmt_sticky_bit #(.KIND(STK_HIGH)) u_page (
    .clk(clk), .rst_n(rst_n), .clr(done), .evt(page_rx_evt),
    .rd_hit(rd_exp), .q(pg_q)
  );

  always_comb begin
    unique case (mgmt_addr)
      A_CTRL:  mgmt_rdata = ctrl_q | (DW'(busy) << (DW - 1));
      A_STAT:  mgmt_rdata = STAT_FIXED | (DW'(aneg_done) << 5) |
                            (DW'(lnk_q) << 2) | (DW'(jab_q) << 1);
      A_ID_HI: mgmt_rdata = ID_HI;
      A_ID_LO: mgmt_rdata = ID_LO;
      A_ADV:   mgmt_rdata = adv_q;
      A_EXP:   mgmt_rdata = EXP_FIXED | (DW'(pg_q) << 1);
      default: mgmt_rdata = '0;
    endcase
  end

  assign reset_busy       = busy;
  assign ctl_loopback     = ctrl_q[14];
  assign ctl_power_down   = ctrl_q[11];
  assign ctl_isolate      = ctrl_q[10];
  assign ctl_col_test     = ctrl_q[7];
  assign ctl_aneg_en      = ctrl_q[12];
  assign ctl_aneg_restart = ctrl_q[9];
  assign ctl_forced_100   = ~ctrl_q[12] & ctrl_q[13];
  assign ctl_forced_full  = ~ctrl_q[12] & ctrl_q[8];
endmodule

// File: rtl/mgmt_regbank_chk.sv
module mgmt_regbank_chk
  import mgmt_pkg::*;
#(
  parameter logic [DW-1:0] ID_HI = 16'h2000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mgmt_rd,
  input logic [AW-1:0] mgmt_addr,
  input logic [DW-1:0] mgmt_rdata,
  input logic          link_good,
  input logic          jabber_evt,
  input logic          page_rx_evt,
  input logic          reset_busy,
  input logic          ctl_aneg_en,
  input logic          ctl_aneg_restart,
  input logic          ctl_forced_100,
  input logic          ctl_forced_full
);
  AST_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_addr == A_CTRL) |-> (mgmt_rdata[15] == reset_busy)); // R1

  AST_LINK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((mgmt_addr == A_STAT) && !$past(link_good)) |-> !mgmt_rdata[2]); // R3

  AST_JABBER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mgmt_addr == A_STAT) && $past(jabber_evt) && !$fell(reset_busy)) |-> mgmt_rdata[1]); // R4

  AST_RESTART_NEEDS_AN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_aneg_restart |-> ctl_aneg_en); // R5

  AST_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_aneg_en |-> (!ctl_forced_100 && !ctl_forced_full)); // R6

  AST_PAGE_COR: assert property (@(posedge clk) disable iff (!rst_n)
    ((mgmt_addr == A_EXP) && $past(mgmt_rd && (mgmt_addr == A_EXP) && !page_rx_evt))
      |-> !mgmt_rdata[1]); // R7

  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_addr == A_ID_HI) |-> (mgmt_rdata == ID_HI)); // R9

  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_addr == A_CTRL) |-> (mgmt_rdata[6:0] == 7'd0)); // R10
endmodule

bind mgmt_regbank mgmt_regbank_chk #(.ID_HI(ID_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .mgmt_rd(mgmt_rd), .mgmt_addr(mgmt_addr),
  .mgmt_rdata(mgmt_rdata), .link_good(link_good), .jabber_evt(jabber_evt),
  .page_rx_evt(page_rx_evt), .reset_busy(reset_busy), .ctl_aneg_en(ctl_aneg_en),
  .ctl_aneg_restart(ctl_aneg_restart), .ctl_forced_100(ctl_forced_100),
  .ctl_forced_full(ctl_forced_full)
);

// File: tb/mgmt_regbank_test.sv
`timescale 1ns/1ps
module mgmt_regbank_test;
  localparam int RC = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mgmt_wr, mgmt_rd;
  logic [4:0]  mgmt_addr;
  logic [15:0] mgmt_wdata, mgmt_rdata;
  logic        s_spd, s_an, s_fd;
  logic [3:0]  s_adv;
  logic        link_good, jabber_evt, page_rx_evt, aneg_done, aneg_started;
  logic        reset_busy, ctl_loopback, ctl_power_down, ctl_isolate, ctl_col_test;
  logic        ctl_aneg_en, ctl_aneg_restart, ctl_forced_100, ctl_forced_full;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mgmt_regbank #(.RST_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd),
    .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
    .strap_speed100(s_spd), .strap_aneg_en(s_an), .strap_full_duplex(s_fd),
    .strap_adv(s_adv), .link_good(link_good), .jabber_evt(jabber_evt),
    .page_rx_evt(page_rx_evt), .aneg_done(aneg_done), .aneg_started(aneg_started),
    .reset_busy(reset_busy), .ctl_loopback(ctl_loopback), .ctl_power_down(ctl_power_down),
    .ctl_isolate(ctl_isolate), .ctl_col_test(ctl_col_test), .ctl_aneg_en(ctl_aneg_en),
    .ctl_aneg_restart(ctl_aneg_restart), .ctl_forced_100(ctl_forced_100),
    .ctl_forced_full(ctl_forced_full)
  );

  // ---------------- behavioural reference ----------------
  bit        m_busy, m_capd;
  int        m_left;
  bit        c_spd, c_an, c_fd;
  bit [3:0]  c_adv;
  bit [15:0] m_c0, m_adv;
  bit        m_lnk, m_jab, m_pg;

  task automatic model_reset();
    m_busy = 1; m_left = 0; m_capd = 0;
    c_spd = 0; c_an = 0; c_fd = 0; c_adv = 0;
    m_c0 = 0; m_adv = 0; m_lnk = 0; m_jab = 0; m_pg = 0;
  endtask

  task automatic model_update();
    bit fin, rd1, rd6, wr0, wr4, go;
    bit nl, nj, np;
    bit [15:0] nc0, na;
    if (!rst_n) begin model_reset(); return; end
    fin = m_busy && (m_left == 0);
    rd1 = mgmt_rd && mgmt_addr == 1;
    rd6 = mgmt_rd && mgmt_addr == 6;
    wr0 = mgmt_wr && mgmt_addr == 0;
    wr4 = mgmt_wr && mgmt_addr == 4;
    go  = wr0 && mgmt_wdata[15] && !m_busy;
    nl = link_good && (m_lnk || rd1);
    nj = jabber_evt || (m_jab && !rd1);
    np = page_rx_evt || (m_pg && !rd6);
    nc0 = m_c0; na = m_adv;
    nc0[9] = m_c0[9] && !aneg_started;
    if (wr0) begin
      nc0 = mgmt_wdata & 16'h7D80;
      nc0[9] = mgmt_wdata[12] && (mgmt_wdata[9] || (m_c0[9] && !aneg_started));
    end
    if (wr4) na = (mgmt_wdata & 16'hADE0) | 16'h0001;
    if (fin) begin
      if (!m_capd) begin c_spd = s_spd; c_an = s_an; c_fd = s_fd; c_adv = s_adv; end
      m_capd = 1;
      nc0 = 0; nc0[13] = c_spd; nc0[12] = c_an; nc0[8] = c_fd;
      na = {7'd0, c_adv, 5'b00001};
      nl = 0; nj = 0; np = 0;
      m_busy = 0;
    end else if (go) begin
      m_busy = 1; m_left = RC - 1;
    end else if (m_busy) begin
      m_left--;
    end
    m_c0 = nc0; m_adv = na; m_lnk = nl; m_jab = nj; m_pg = np;
  endtask

  function automatic bit [15:0] model_rdata(input bit [4:0] a);
    case (a)
      0: return (m_c0 & 16'h7F80) | {m_busy, 15'd0};
      1: return 16'h7849 | {10'd0, aneg_done, 2'b00, m_lnk, m_jab, 1'b0};
      2: return 16'h2000;
      3: return 16'h5C90;
      4: return m_adv;
      6: return 16'h0004 | {14'd0, m_pg, 1'b0};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input bit [4:0] a);
    case (a)
      0: return "R10";
      1: return "R3";
      4: return "R2";
      6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(tag_of(mgmt_addr), mgmt_rdata, model_rdata(mgmt_addr));
    chk("R1", 16'(reset_busy), 16'(m_busy));
    chk("R10", {12'd0, ctl_loopback, ctl_power_down, ctl_isolate, ctl_col_test},
        {12'd0, m_c0[14], m_c0[11], m_c0[10], m_c0[7]});
    chk("R5", {14'd0, ctl_aneg_en, ctl_aneg_restart}, {14'd0, m_c0[12], m_c0[9]});
    chk("R6", {14'd0, ctl_forced_100, ctl_forced_full},
        {14'd0, !m_c0[12] && m_c0[13], !m_c0[12] && m_c0[8]});
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic look(input bit [4:0] a, input string tag, input bit [15:0] mask,
                      input bit [15:0] exp);
    mgmt_addr = a; mgmt_rd = 0; mgmt_wr = 0;
    #1 chk(tag, mgmt_rdata & mask, exp);
    step();
  endtask

  task automatic rd_pulse(input bit [4:0] a);
    mgmt_addr = a; mgmt_rd = 1; step(); mgmt_rd = 0;
  endtask

  task automatic wr(input bit [4:0] a, input bit [15:0] d);
    mgmt_addr = a; mgmt_wdata = d; mgmt_wr = 1; step(); mgmt_wr = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int n;
    model_reset();
    rst_n = 0; mgmt_wr = 0; mgmt_rd = 0; mgmt_addr = 0; mgmt_wdata = 0;
    s_spd = 1; s_an = 0; s_fd = 1; s_adv = 4'b1010;
    link_good = 0; jabber_evt = 0; page_rx_evt = 0; aneg_done = 0; aneg_started = 0;
    @(negedge clk);
    step(); step();
    look(0, "R1", 16'hFFFF, 16'h8000);           // busy during power-on reset
    rst_n = 1;
    step();                                      // strap capture edge
    look(0, "R2", 16'hFFFF, 16'h2100);
    look(4, "R2", 16'hFFFF, 16'h0141);
    look(1, "R8", 16'hFFFF, 16'h7849);

    // R3 link latch-low
    link_good = 1; step();
    look(1, "R3", 16'h0004, 16'h0000);
    rd_pulse(1);
    look(1, "R3", 16'h0004, 16'h0004);
    link_good = 0; step(); link_good = 1; step();
    look(1, "R3", 16'h0004, 16'h0000);
    link_good = 0; mgmt_addr = 1; mgmt_rd = 1; step(); mgmt_rd = 0; link_good = 1;
    look(1, "R11", 16'h0004, 16'h0000);
    rd_pulse(1);
    look(1, "R3", 16'h0004, 16'h0004);

    // R4 jabber latch-high
    jabber_evt = 1; step(); jabber_evt = 0;
    look(1, "R4", 16'h0002, 16'h0002);
    look(1, "R4", 16'h0002, 16'h0002);
    jabber_evt = 1; mgmt_addr = 1; mgmt_rd = 1; step(); jabber_evt = 0; mgmt_rd = 0;
    look(1, "R11", 16'h0002, 16'h0002);
    rd_pulse(1);
    look(1, "R4", 16'h0002, 16'h0000);

    // R7 page received, clear on read
    page_rx_evt = 1; step(); page_rx_evt = 0;
    look(6, "R7", 16'hFFFF, 16'h0006);
    rd_pulse(6);
    look(6, "R7", 16'hFFFF, 16'h0004);
    aneg_done = 1;
    look(1, "R8", 16'h0020, 16'h0020);

    // R5 restart and R6 forced mode
    wr(0, 16'h1200);
    #1 chk("R5", 16'(ctl_aneg_restart), 16'h1);
    chk("R6", {14'd0, ctl_forced_100, ctl_forced_full}, 16'h0);
    wr(0, 16'h1000);
    #1 chk("R5", 16'(ctl_aneg_restart), 16'h1);
    aneg_started = 1; step(); aneg_started = 0;
    #1 chk("R5", 16'(ctl_aneg_restart), 16'h0);
    wr(0, 16'h0200);
    #1 chk("R5", 16'(ctl_aneg_restart), 16'h0);
    wr(0, 16'h2100);
    #1 chk("R6", {14'd0, ctl_forced_100, ctl_forced_full}, 16'h3);
    wr(0, 16'h3100);
    #1 chk("R6", {14'd0, ctl_forced_100, ctl_forced_full}, 16'h0);

    // R10 plain bits and reserved bits
    wr(0, 16'h4CFF);
    look(0, "R10", 16'hFFFF, 16'h4C80);
    #1 chk("R10", {12'd0, ctl_loopback, ctl_power_down, ctl_isolate, ctl_col_test}, 16'hF);

    // R8 / R9 constant and unused locations
    wr(2, 16'h0000); look(2, "R9", 16'hFFFF, 16'h2000);
    wr(3, 16'hFFFF); look(3, "R9", 16'hFFFF, 16'h5C90);
    wr(9, 16'hFFFF); look(9, "R9", 16'hFFFF, 16'h0000);
    wr(31, 16'hFFFF); look(31, "R9", 16'hFFFF, 16'h0000);
    wr(1, 16'h0000); look(1, "R8", 16'hFFD9, 16'h7849);
    wr(4, 16'hFFFF); look(4, "R8", 16'hFFFF, 16'hADE1);
    wr(6, 16'hFFFF); look(6, "R8", 16'hFFFD, 16'h0004);

    // R1 / R2 / R12 soft reset
    s_spd = 0; s_an = 1; s_fd = 0; s_adv = 4'b0101;
    jabber_evt = 1; step(); jabber_evt = 0;
    wr(0, 16'h8000);
    mgmt_addr = 0; mgmt_wdata = 16'hC000; mgmt_wr = 1;  // lands while busy
    n = 0;
    while (reset_busy === 1'b1 && n < 1000) begin
      n++; step(); mgmt_wr = 0;
    end
    chk("R1", 16'(n), 16'(RC));
    look(0, "R12", 16'hFFFF, 16'h2100);
    look(4, "R2", 16'hFFFF, 16'h0141);
    look(1, "R1", 16'h0002, 16'h0000);
    look(0, "R1", 16'h8000, 16'h0000);

    repeat (3) step();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule